// File: doc/BRIEF.md
# Chained-Descriptor Receive DMA Engine

This engine takes bytes from a serial receiver and places them in memory. Where each byte goes is set by a linked chain of descriptors. Every descriptor names a data buffer and points to the next descriptor. All descriptors sit in one 64 KB page, and an 8-bit page register selects that page. Software prepares the chain and sets the page, the first descriptor, a stop descriptor and a common buffer length. It then starts the engine.

Before data can flow, the engine spends a fixed set-up window reading the current descriptor. Each received byte then costs one memory write cycle. A buffer is closed when it fills up or when a frame ends. The engine then writes the byte count and a status byte back into that descriptor and follows the link. It stops when the link reaches the stop descriptor, which software may move forward while the engine runs. In single-frame mode it also stops after the first completed frame. A byte that arrives while the engine cannot accept it is lost, and a sticky flag records the loss.

Top module: `rxchain_dma`

## Requirements
- R1: Every descriptor access uses address {page register, 16-bit descriptor address}. The descriptor address wraps within the page.
- R2: Descriptor fetch and start:
  - The engine is started by writing 1 to control bit 0 while idle, with current not equal to stop.
  - In the next FETCH_CYC cycles it first reads descriptor bytes +0 to +4, one per cycle. +0/+1 hold the link, low byte first. +2/+3/+4 hold the buffer address, little-endian.
  - Received bytes are accepted only after this window.
- R3: Register map on reg_addr:
  - 0 is control/status. Bit 0 reads busy and starts on write. Bit 1 is multi-frame. Bit 2 is stopped-at-end. Bit 3 is overflow.
  - 1 is the page, 2 is the current descriptor, 3 is the stop descriptor, 4 is the buffer length.
  - Page, current, length and mode are written only while idle.
- R4: While the data phase is active, each byte with rx_valid is written in that same cycle to buffer address + bytes already stored in this buffer.
- R5: The buffer is closed when its byte count reaches the buffer length, or on a byte that carries rx_eof.
- R6: Write-back when a buffer closes:
  - In the first three cycles of the SWITCH_CYC switch window, the engine writes the count (low byte, then high byte) to descriptor +6/+7 and the status byte to +8.
  - Status is 0x80 if the frame ended, otherwise 0x40.
  - The current descriptor then becomes the link.
- R7: The engine halts without further memory access when the next current descriptor equals the stop register, or when current equals stop at start. On this halt it clears busy and sets bit 2. A new start clears bit 2.
- R8: In single-frame mode (bit 1 = 0) the engine halts after the write-back of a frame-ending buffer and leaves bit 2 clear. In multi-frame mode it continues.
- R9: A byte presented outside the data phase is not written to memory and sets bit 3. Bit 3 stays set until software writes control with bit 3 = 1.
- R10: The stop register can be written while the engine runs. The new value governs the next halt decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | Byte is the last of its frame |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the request cycle |

## Verification
The bench keeps the defaults FETCH_CYC = 18 and SWITCH_CYC = 8 and programs a buffer length of 4. This length lets a six-byte frame span two buffers, so both closing reasons and both status codes occur within a few hundred cycles. The cycle-exact model follows both fixed windows, so an early or late fetch or write-back is seen as a mismatch on the memory port. The stop register is moved during a run, and the chain is started directly on its stop descriptor.

// File: rtl/rxchain_pkg.sv
package rxchain_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_RUN   = 2'd2,
        PH_WBACK = 2'd3
    } phase_t;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_PAGE = 3'd1;
    localparam logic [2:0] RA_CUR  = 3'd2;
    localparam logic [2:0] RA_STOP = 3'd3;
    localparam logic [2:0] RA_LEN  = 3'd4;

    localparam int unsigned FETCH_BYTES = 5;
    localparam int unsigned WB_BYTES    = 3;
    localparam logic [15:0] OFS_DL      = 16'd6;
    localparam logic [7:0]  ST_FRAME    = 8'h80;
    localparam logic [7:0]  ST_FULL     = 8'h40;
endpackage

// File: rtl/rxchain_regs.sv
module rxchain_regs
    import rxchain_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        busy,
    input  logic [15:0] cur,
    input  logic        stop_end,
    input  logic        ovf_set,
    output logic        start,
    output logic        cur_ld,
    output logic [7:0]  page,
    output logic [15:0] stop_ptr,
    output logic [15:0] buf_len,
    output logic        multi
);
    typedef struct packed {
        logic [7:0]  page;
        logic [15:0] stop;
        logic [15:0] len;
        logic        multi;
        logic        endhit;
        logic        ovf;
    } regs_t;

    regs_t q, d;
    logic  w1c;

    always_comb begin
        d      = q;
        start  = 1'b0;
        cur_ld = 1'b0;
        w1c    = 1'b0;
        if (reg_we) begin
            unique case (reg_addr)
                RA_CTRL: begin
                    w1c = reg_wdata[3];
                    if (!busy) begin
                        d.multi = reg_wdata[1];
                        if (reg_wdata[0]) begin
                            start    = 1'b1;
                            d.endhit = 1'b0;
                        end
                    end
                end
                RA_PAGE: if (!busy) d.page = reg_wdata[7:0];
                RA_CUR:  cur_ld = !busy;
                RA_STOP: d.stop = reg_wdata;
                RA_LEN:  if (!busy) d.len = reg_wdata;
                default: ;
            endcase
        end
        if (w1c)      d.ovf    = 1'b0;
        if (ovf_set)  d.ovf    = 1'b1;
        if (stop_end) d.endhit = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (reg_addr)
            RA_CTRL: reg_rdata = {12'd0, q.ovf, q.endhit, q.multi, busy};
            RA_PAGE: reg_rdata = {8'd0, q.page};
            RA_CUR:  reg_rdata = cur;
            RA_STOP: reg_rdata = q.stop;
            RA_LEN:  reg_rdata = q.len;
            default: reg_rdata = '0;
        endcase
    end

    assign page     = q.page;
    assign stop_ptr = q.stop;
    assign buf_len  = q.len;
    assign multi    = q.multi;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovf && !(reg_we && reg_addr == RA_CTRL && reg_wdata[3])) |=> q.ovf); // R9
    AST_ENDHIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        stop_end |=> q.endhit); // R7
endmodule

// File: rtl/rxchain_seq.sv
module rxchain_seq
    import rxchain_pkg::*;
#(
    parameter int unsigned FETCH_CYC  = 18,
    parameter int unsigned SWITCH_CYC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        cur_ld,
    input  logic [15:0] cur_wdata,
    input  logic [7:0]  page,
    input  logic [15:0] stop_ptr,
    input  logic [15:0] buf_len,
    input  logic        multi,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_eof,
    output logic        mem_req,
    output logic        mem_we,
    output logic [23:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic [15:0] cur,
    output logic        stop_end,
    output logic        ovf_set
);
    localparam int unsigned TMAX = (FETCH_CYC > SWITCH_CYC) ? FETCH_CYC : SWITCH_CYC;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] T_FETCH_END = TW'(FETCH_CYC - 1);
    localparam logic [TW-1:0] T_SW_END    = TW'(SWITCH_CYC - 1);

    typedef struct packed {
        phase_t        ph;
        logic [TW-1:0] tim;
        logic [15:0]   cur;
        logic [15:0]   nxt;
        logic [23:0]   bp;
        logic [15:0]   cnt;
        logic          fend;
        logic [7:0]    st;
    } seq_t;

    seq_t        q, d;
    logic [15:0] cnt_inc;

    initial begin
        if (FETCH_CYC < FETCH_BYTES) $error("FETCH_CYC too small");
        if (SWITCH_CYC < WB_BYTES)   $error("SWITCH_CYC too small");
    end

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        stop_end  = 1'b0;
        ovf_set   = rx_valid && (q.ph != PH_RUN);
        cnt_inc   = q.cnt + 16'd1;
        unique case (q.ph)
            PH_IDLE: begin
                if (cur_ld) d.cur = cur_wdata;
                if (start) begin
                    if (q.cur == stop_ptr) begin
                        stop_end = 1'b1;
                    end else begin
                        d.ph  = PH_FETCH;
                        d.tim = '0;
                    end
                end
            end
            PH_FETCH: begin
                if (q.tim < TW'(FETCH_BYTES)) begin
                    mem_req  = 1'b1;
                    mem_addr = {page, q.cur + 16'(q.tim)};
                    unique case (q.tim[2:0])
                        3'd0:    d.nxt[7:0]   = mem_rdata;
                        3'd1:    d.nxt[15:8]  = mem_rdata;
                        3'd2:    d.bp[7:0]    = mem_rdata;
                        3'd3:    d.bp[15:8]   = mem_rdata;
                        default: d.bp[23:16]  = mem_rdata;
                    endcase
                end
                d.tim = q.tim + 1'b1;
                if (q.tim == T_FETCH_END) begin
                    d.ph  = PH_RUN;
                    d.cnt = '0;
                end
            end
            PH_RUN: begin
                if (rx_valid) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = q.bp + {8'd0, q.cnt};
                    mem_wdata = rx_data;
                    d.cnt     = cnt_inc;
                    if (cnt_inc == buf_len || rx_eof) begin
                        d.ph   = PH_WBACK;
                        d.tim  = '0;
                        d.fend = rx_eof;
                        d.st   = rx_eof ? ST_FRAME : ST_FULL;
                    end
                end
            end
            PH_WBACK: begin
                if (q.tim < TW'(WB_BYTES)) begin
                    mem_req  = 1'b1;
                    mem_we   = 1'b1;
                    mem_addr = {page, q.cur + OFS_DL + 16'(q.tim)};
                    unique case (q.tim[1:0])
                        2'd0:    mem_wdata = q.cnt[7:0];
                        2'd1:    mem_wdata = q.cnt[15:8];
                        default: mem_wdata = q.st;
                    endcase
                end
                d.tim = q.tim + 1'b1;
                if (q.tim == T_SW_END) begin
                    d.cur = q.nxt;
                    if (q.fend && !multi) begin
                        d.ph = PH_IDLE;
                    end else if (q.nxt == stop_ptr) begin
                        d.ph     = PH_IDLE;
                        stop_end = 1'b1;
                    end else begin
                        d.ph  = PH_FETCH;
                        d.tim = '0;
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy = (q.ph != PH_IDLE);
    assign cur  = q.cur;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE) |-> !mem_req); // R7
    AST_FETCH_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_FETCH && mem_req) |-> (!mem_we && mem_addr[23:16] == page)); // R1
    AST_CLOSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_RUN && d.ph == PH_WBACK) |-> (d.cnt == buf_len || rx_eof)); // R5
    AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_end |=> !busy); // R7
    AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_set && mem_we) |-> (q.ph == PH_WBACK)); // R9
endmodule

// File: rtl/rxchain_dma.sv
module rxchain_dma
    import rxchain_pkg::*;
#(
    parameter int unsigned FETCH_CYC  = 18,
    parameter int unsigned SWITCH_CYC = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_eof,
    output logic        mem_req,
    output logic        mem_we,
    output logic [23:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata
);
    logic        busy, start, cur_ld, stop_end, ovf_set, multi;
    logic [15:0] cur, stop_ptr, buf_len;
    logic [7:0]  page;

    rxchain_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .cur(cur), .stop_end(stop_end), .ovf_set(ovf_set),
        .start(start), .cur_ld(cur_ld), .page(page), .stop_ptr(stop_ptr),
        .buf_len(buf_len), .multi(multi)
    );

    rxchain_seq #(.FETCH_CYC(FETCH_CYC), .SWITCH_CYC(SWITCH_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(start), .cur_ld(cur_ld), .cur_wdata(reg_wdata),
        .page(page), .stop_ptr(stop_ptr), .buf_len(buf_len), .multi(multi),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .cur(cur), .stop_end(stop_end), .ovf_set(ovf_set)
    );
endmodule

// File: tb/sim_rxchain_dma.sv
module sim_rxchain_dma;
    localparam int FC = 18;
    localparam int SC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_eof = 1'b0;
    logic        mem_req, mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    rxchain_dma #(.FETCH_CYC(FC), .SWITCH_CYC(SC)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eof(rx_eof), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [7:0] mem [0:4095];
    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[11:0]] <= mem_wdata;

    // behavioural reference model: 0 idle, 1 descriptor read, 2 data, 3 write-back
    int          ph, t;
    logic [15:0] mcur, mnxt, mcnt, mend, mlen;
    logic [23:0] mbp;
    logic [7:0]  mbase, mst;
    logic        mmf, mfend;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; t = 0; mcur = 0; mnxt = 0; mcnt = 0; mend = 0; mlen = 0;
            mbp = 0; mbase = 0; mst = 0; mmf = 0; mfend = 0;
        end else begin
            if (reg_we && reg_addr == 3) mend = reg_wdata;
            if (ph == 0) begin
                if (reg_we) begin
                    if (reg_addr == 1) mbase = reg_wdata[7:0];
                    if (reg_addr == 2) mcur = reg_wdata;
                    if (reg_addr == 4) mlen = reg_wdata;
                    if (reg_addr == 0) begin
                        mmf = reg_wdata[1];
                        if (reg_wdata[0] && mcur != mend) begin ph = 1; t = 0; end
                    end
                end
            end else if (ph == 1) begin
                logic [15:0] a;
                a = mcur + 16'(t);
                if (t == 0) mnxt[7:0]  = mem[a[11:0]];
                if (t == 1) mnxt[15:8] = mem[a[11:0]];
                if (t == 2) mbp[7:0]   = mem[a[11:0]];
                if (t == 3) mbp[15:8]  = mem[a[11:0]];
                if (t == 4) mbp[23:16] = mem[a[11:0]];
                t++;
                if (t == FC) begin ph = 2; mcnt = 0; end
            end else if (ph == 2) begin
                if (rx_valid) begin
                    mcnt++;
                    if (mcnt == mlen || rx_eof) begin
                        ph = 3; t = 0; mfend = rx_eof;
                        mst = rx_eof ? 8'h80 : 8'h40;
                    end
                end
            end else begin
                t++;
                if (t == SC) begin
                    mcur = mnxt;
                    if (mfend && !mmf) ph = 0;
                    else if (mnxt == mend) ph = 0;
                    else begin ph = 1; t = 0; end
                end
            end
        end
    end

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison of the memory port
    always @(negedge clk) begin
        if (rst_n) begin
            logic        er, ew;
            logic [23:0] ea;
            logic [7:0]  ed;
            string       tg;
            er = 0; ew = 0; ea = 0; ed = 0; tg = "R7 idle port";
            if (ph == 1) begin
                tg = "R2 R1 fetch port";
                if (t < 5) begin er = 1; ea = {mbase, mcur + 16'(t)}; end
            end else if (ph == 2) begin
                tg = "R4 data port";
                if (rx_valid) begin er = 1; ew = 1; ea = mbp + {8'd0, mcnt}; ed = rx_data; end
            end else if (ph == 3) begin
                tg = "R6 write-back port";
                if (t < 3) begin
                    er = 1; ew = 1; ea = {mbase, mcur + 16'd6 + 16'(t)};
                    ed = (t == 0) ? mcnt[7:0] : (t == 1) ? mcnt[15:8] : mst;
                end
            end
            if (er) check(tg, {6'd0, mem_req, mem_we, mem_addr, mem_wdata}, {6'd0, er, ew, ea, ed});
            else    check(tg, {39'd0, mem_req}, 40'd0);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        @(posedge clk); #1;
        reg_we = 1; reg_addr = a; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a; #1; v = reg_rdata;
    endtask

    task automatic raw(input logic [7:0] b, input logic e);
        @(posedge clk); #1;
        rx_valid = 1; rx_data = b; rx_eof = e;
        @(posedge clk); #1;
        rx_valid = 0; rx_eof = 0;
    endtask

    task automatic send(input logic [7:0] b, input logic e);
        while (ph != 2) begin @(posedge clk); #1; end
        rx_valid = 1; rx_data = b; rx_eof = e;
        @(posedge clk); #1;
        rx_valid = 0; rx_eof = 0;
    endtask

    task automatic wait_idle();
        while (ph != 0) begin @(posedge clk); #1; end
    endtask

    task automatic mkdesc(input logic [15:0] a, input logic [15:0] cp, input logic [23:0] bp);
        mem[a[11:0]]      = cp[7:0];
        mem[a[11:0] + 1]  = cp[15:8];
        mem[a[11:0] + 2]  = bp[7:0];
        mem[a[11:0] + 3]  = bp[15:8];
        mem[a[11:0] + 4]  = bp[23:16];
    endtask

    task automatic mchk(input string tag, input logic [11:0] a, input logic [7:0] e);
        check(tag, {32'd0, mem[a]}, {32'd0, e});
    endtask

    initial begin
        #(20 * 100000);
        nerr++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        mkdesc(16'h0100, 16'h0110, 24'h5A0800);
        mkdesc(16'h0110, 16'h0120, 24'h5A0810);
        mkdesc(16'h0120, 16'h0130, 24'h5A0820);
        mkdesc(16'h0130, 16'h0140, 24'h5A0830);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        rd(0, v); check("R3 reset control", {24'd0, v}, 40'h0);
        rd(4, v); check("R3 reset length", {24'd0, v}, 40'h0);

        // multi-frame run, stop moved during the run
        wr(1, 16'h005A); wr(2, 16'h0100); wr(3, 16'h0120); wr(4, 16'd4);
        rd(1, v); check("R3 page readback", {24'd0, v}, 40'h5A);
        wr(0, 16'h0003);
        rd(0, v); check("R2 busy after start", {24'd0, v}, 40'h3);
        send(8'h11, 0);
        wr(3, 16'h0130);
        send(8'h12, 0); send(8'h13, 0); send(8'h14, 0);
        send(8'h15, 0); send(8'h16, 1);
        send(8'h21, 0); send(8'h22, 0); send(8'h23, 1);
        wait_idle();
        mchk("R4 buf0 b0", 12'h800, 8'h11);
        mchk("R4 buf0 b3", 12'h803, 8'h14);
        mchk("R5 buf1 b0 after full", 12'h810, 8'h15);
        mchk("R4 buf1 b1", 12'h811, 8'h16);
        mchk("R4 buf2 b2", 12'h822, 8'h23);
        mchk("R6 dl lo d0", 12'h106, 8'h04);
        mchk("R6 dl hi d0", 12'h107, 8'h00);
        mchk("R6 status full d0", 12'h108, 8'h40);
        mchk("R6 dl lo d1", 12'h116, 8'h02);
        mchk("R6 status eof d1", 12'h118, 8'h80);
        mchk("R5 dl eof d2", 12'h126, 8'h03);
        rd(0, v); check("R7 stopped at end", {24'd0, v}, 40'h6);
        rd(2, v); check("R10 moved stop governs halt", {24'd0, v}, 40'h0130);

        // byte while halted
        raw(8'h99, 0);
        mchk("R9 dropped byte not written", 12'h830, 8'h00);
        rd(0, v); check("R9 overflow set", {24'd0, v}, 40'hE);
        repeat (2) @(posedge clk);
        #1 rd(0, v); check("R9 overflow sticky", {24'd0, v}, 40'hE);
        wr(0, 16'h000A);
        rd(0, v); check("R9 overflow cleared", {24'd0, v}, 40'h6);

        // single-frame run, byte during descriptor read
        wr(2, 16'h0100); wr(0, 16'h0001);
        raw(8'h77, 0);
        rd(0, v); check("R9 overflow during fetch", {24'd0, v}, 40'h9);
        send(8'h31, 0); send(8'h32, 1);
        wait_idle();
        mchk("R8 buf0 b0", 12'h800, 8'h31);
        mchk("R8 buf0 b2 untouched", 12'h802, 8'h13);
        mchk("R8 dl d0", 12'h106, 8'h02);
        rd(0, v); check("R8 single-frame halt", {24'd0, v}, 40'h8);
        rd(2, v); check("R8 current advanced", {24'd0, v}, 40'h0110);

        // start on the stop descriptor
        wr(2, 16'h0130); wr(0, 16'h0001);
        repeat (5) @(posedge clk);
        #1 rd(0, v); check("R7 start at stop", {24'd0, v}, 40'hC);
        rd(2, v); check("R7 current kept", {24'd0, v}, 40'h0130);

        repeat (3) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule